// File: doc/BRIEF.md
# Scatter-Gather Descriptor Coalescer

This block turns a list of scatter-gather entries into buffer descriptors for a descriptor ring. The ring has N data slots and one link slot at index N. A caller starts a pass with four values: its pending write count, the consumer's read count, the list length and the starting remote address. It then streams entries, each made of a 64-bit buffer address, a byte length and a last flag. Entries that continue exactly where the previous one ended are folded into the open descriptor, as long as the total stays within the byte cap. Any other entry closes the open descriptor and opens a new one in the next free slot.

Each opened descriptor is reported by an open strobe that carries its slot and its initial fields. Each closed descriptor is reported by a separate close strobe that carries its final byte count. A pass ends with a done pulse. The pulse carries an error flag, a ring-full flag, the number of entries that were not consumed, and the number of ring positions the caller must add to its pending write count. If the consumer's read slot is reached before the list is exhausted, the pass stops partway, so the caller can resume the rest later.

Top module: `sg_coalescer`

## Requirements
- R1: After reset the block is idle. busy, ent_ready, done, op_valid and cl_valid are all 0.
- R2: An entry is merged into the open descriptor when two conditions hold: its address equals the previous entry's address plus that entry's length, and the summed length is at most MAX_BYTES. A sum exactly equal to MAX_BYTES still merges. A merge produces no strobe.
- R3: An entry that is not contiguous, or that would push the sum above MAX_BYTES, closes the open descriptor and opens a new one. The close strobe carries the old slot and its accumulated count. The open strobe for the new slot appears in the same cycle.
- R4: An entry longer than MAX_BYTES is not accepted and ends the pass at once. The done pulse then shows done_err=1, done_full=0, done_added=0 and done_left equal to the list length minus the entries already accepted.
- R5: The first field word of an opened descriptor (op_word0) is laid out as follows. Bits 31:29 hold 3'b001. Bits 22:19 hold the transaction type. Bits 15:0 hold the destination ID. All other bits are zero.
- R6: The second field word of an opened descriptor (op_word1) carries the remote address bits 1:0 in bits 31:30 and zeros elsewhere. op_raddr is the remote address shifted right by 2. op_buf is the entry's buffer address.
- R7: The remote address starts at raddr_in and grows by the length of every accepted entry, merged or not.
- R8: The first slot is pend_cnt modulo N+1. If that value equals N, the block uses slot 0 and counts one extra position.
- R9: Each opened descriptor adds 1 to the added count and moves to the next slot. Leaving slot N-1 wraps to slot 0 and adds 1 more for the link slot. op_slot never equals N.
- R10: When a new descriptor is needed for any entry after the first, and the current slot equals rd_cnt modulo N+1, three things happen. The open descriptor is closed, the entry is not accepted, and done shows done_full=1 with done_left equal to the list length minus the entries accepted and done_added equal to the positions used so far.
- R11: A descriptor's byte count appears only on its close strobe. After the last entry is accepted, the block sends the final close strobe and done in the same cycle, one cycle after the cycle in which the entry was visible on the outputs.
- R12: A pass that ends normally reports done_err=0, done_full=0, done_left=0 and the total added count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when idle |
| pend_cnt | input | CNT_W | Caller's pending write count |
| rd_cnt | input | CNT_W | Consumer read count |
| sg_len | input | CNT_W | Number of entries in the list |
| raddr_in | input | 64 | Starting remote address |
| dest_id | input | 16 | Destination ID for descriptors |
| ttype | input | 4 | Transaction type field |
| ent_valid | input | 1 | Entry present |
| ent_ready | output | 1 | Entry accepted at this edge |
| ent_addr | input | 64 | Entry buffer address |
| ent_len | input | LEN_W | Entry byte length |
| ent_last | input | 1 | Entry is the last of the list |
| op_valid | output | 1 | Descriptor open strobe |
| op_slot | output | SLOT_W | Slot being opened |
| op_word0 | output | 32 | Type, transaction type, destination |
| op_word1 | output | 32 | Remote address low bits |
| op_raddr | output | 64 | Remote address shifted right by 2 |
| op_buf | output | 64 | Buffer address |
| cl_valid | output | 1 | Descriptor close strobe |
| cl_slot | output | SLOT_W | Slot being closed |
| cl_count | output | LEN_W | Final byte count |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished (one cycle) |
| done_err | output | 1 | Oversized entry ended the pass |
| done_full | output | 1 | Ring-full stop |
| done_added | output | CNT_W | Positions to add to the pending count |
| done_left | output | CNT_W | Entries not consumed |

## Verification
A wrong slot counter shows up on the first open strobe after it goes wrong, either as a misplaced op_slot or as a wrong done_added at the end of the pass. A bad merge register shows up as an extra or missing close strobe, or as a wrong cl_count, no later than the next non-contiguous entry or the final flush. A stale remote-address register corrupts op_raddr and op_word1 on the very next open. The ring-full and error stops show up within one cycle as a refused entry and a done pulse whose flags and residue disagree with the accepted-entry count.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } sgc_state_t;

    localparam logic [2:0] DESC_KIND_DATA = 3'd1;
    localparam int         KIND_LSB       = 29;
    localparam int         TTYPE_LSB      = 19;

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [63:0] raddr;
        logic [63:0] buf_addr;
    } bd_open_t;

    function automatic logic [31:0] make_word0(input logic [3:0] tt, input logic [15:0] dst);
        logic [31:0] w;
        w = '0;
        w[KIND_LSB +: 3]  = DESC_KIND_DATA;
        w[TTYPE_LSB +: 4] = tt;
        w[15:0]           = dst;
        return w;
    endfunction

    function automatic logic [31:0] make_word1(input logic [1:0] lo);
        return {lo, 30'd0};
    endfunction

endpackage

// File: rtl/sgc_slot_track.sv
module sgc_slot_track #(
    parameter int N      = 128,
    parameter int CNT_W  = 32,
    parameter int SLOT_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  pend_cnt,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [CNT_W-1:0]  added
);
    localparam logic [CNT_W-1:0]  RING_LEN = CNT_W'(N + 1);
    localparam logic [SLOT_W-1:0] LINK     = SLOT_W'(N);
    localparam logic [SLOT_W-1:0] LAST_DAT = SLOT_W'(N - 1);

    logic [SLOT_W-1:0] start_slot;
    logic [SLOT_W-1:0] rd_mod;

    always_comb begin
        start_slot = SLOT_W'(pend_cnt % RING_LEN);
        rd_mod     = SLOT_W'(rd_cnt % RING_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= '0;
            rd_slot <= '0;
            added   <= '0;
        end else if (load) begin
            rd_slot <= rd_mod;
            if (start_slot == LINK) begin
                slot  <= '0;
                added <= CNT_W'(1);
            end else begin
                slot  <= start_slot;
                added <= '0;
            end
        end else if (adv) begin
            if (slot == LAST_DAT) begin
                slot  <= '0;
                added <= added + CNT_W'(2);
            end else begin
                slot  <= slot + SLOT_W'(1);
                added <= added + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sgc_merge_unit.sv
module sgc_merge_unit #(
    parameter int LEN_W     = 26,
    parameter int MAX_BYTES = 67108863
) (
    input  logic             have_open,
    input  logic [63:0]      next_addr,
    input  logic [LEN_W-1:0] bcount,
    input  logic [63:0]      ent_addr,
    input  logic [LEN_W-1:0] ent_len,
    output logic             too_big,
    output logic             merge
);
    localparam logic [LEN_W:0] CAP = (LEN_W + 1)'(MAX_BYTES);

    logic [LEN_W:0] sum;

    always_comb begin
        sum     = {1'b0, bcount} + {1'b0, ent_len};
        too_big = {1'b0, ent_len} > CAP;
        merge   = have_open && (ent_addr == next_addr) && (sum <= CAP);
    end
endmodule

// File: rtl/sg_coalescer.sv
module sg_coalescer
    import sgc_pkg::*;
#(
    parameter int N         = 128,
    parameter int LEN_W     = 26,
    parameter int MAX_BYTES = 67108863,
    parameter int CNT_W     = 32,
    parameter int SLOT_W    = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  pend_cnt,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic [CNT_W-1:0]  sg_len,
    input  logic [63:0]       raddr_in,
    input  logic [15:0]       dest_id,
    input  logic [3:0]        ttype,
    input  logic              ent_valid,
    output logic              ent_ready,
    input  logic [63:0]       ent_addr,
    input  logic [LEN_W-1:0]  ent_len,
    input  logic              ent_last,
    output logic              op_valid,
    output logic [SLOT_W-1:0] op_slot,
    output logic [31:0]       op_word0,
    output logic [31:0]       op_word1,
    output logic [63:0]       op_raddr,
    output logic [63:0]       op_buf,
    output logic              cl_valid,
    output logic [SLOT_W-1:0] cl_slot,
    output logic [LEN_W-1:0]  cl_count,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic              done_full,
    output logic [CNT_W-1:0]  done_added,
    output logic [CNT_W-1:0]  done_left
);
    sgc_state_t        st;
    logic [CNT_W-1:0]  ent_idx;
    logic [CNT_W-1:0]  list_len;
    logic [63:0]       raddr;
    logic [63:0]       next_addr;
    logic [LEN_W-1:0]  bcount;
    logic              have_open;
    logic [SLOT_W-1:0] open_slot;
    logic [15:0]       dst_q;
    logic [3:0]        tt_q;
    bd_open_t          bd_next;

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [CNT_W-1:0]  added;
    logic              too_big;
    logic              merge;

    logic in_run, err_hit, acc_merge, new_req, stop_full, do_open, close_prev, accept, load;

    sgc_merge_unit #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_merge (
        .have_open (have_open),
        .next_addr (next_addr),
        .bcount    (bcount),
        .ent_addr  (ent_addr),
        .ent_len   (ent_len),
        .too_big   (too_big),
        .merge     (merge)
    );

    sgc_slot_track #(.N(N), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .pend_cnt (pend_cnt),
        .rd_cnt   (rd_cnt),
        .adv      (do_open),
        .slot     (slot),
        .rd_slot  (rd_slot),
        .added    (added)
    );

    always_comb begin
        load       = (st == ST_IDLE) && start;
        in_run     = (st == ST_RUN);
        err_hit    = in_run && ent_valid && too_big;
        acc_merge  = in_run && ent_valid && !too_big && merge;
        new_req    = in_run && ent_valid && !too_big && !merge;
        stop_full  = new_req && (ent_idx != '0) && (slot == rd_slot);
        do_open    = new_req && !stop_full;
        close_prev = new_req && have_open;
        accept     = acc_merge || do_open;
        ent_ready  = in_run && !too_big && !stop_full;
        busy       = (st != ST_IDLE);

        bd_next.w0       = make_word0(tt_q, dst_q);
        bd_next.w1       = make_word1(raddr[1:0]);
        bd_next.raddr    = raddr >> 2;
        bd_next.buf_addr = ent_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ent_idx    <= '0;
            list_len   <= '0;
            raddr      <= '0;
            next_addr  <= '0;
            bcount     <= '0;
            have_open  <= 1'b0;
            open_slot  <= '0;
            dst_q      <= '0;
            tt_q       <= '0;
            op_valid   <= 1'b0;
            op_slot    <= '0;
            op_word0   <= '0;
            op_word1   <= '0;
            op_raddr   <= '0;
            op_buf     <= '0;
            cl_valid   <= 1'b0;
            cl_slot    <= '0;
            cl_count   <= '0;
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_full  <= 1'b0;
            done_added <= '0;
            done_left  <= '0;
        end else begin
            op_valid <= 1'b0;
            cl_valid <= 1'b0;
            done     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st        <= ST_RUN;
                        ent_idx   <= '0;
                        list_len  <= sg_len;
                        raddr     <= raddr_in;
                        have_open <= 1'b0;
                        bcount    <= '0;
                        dst_q     <= dest_id;
                        tt_q      <= ttype;
                    end
                end
                ST_RUN: begin
                    if (err_hit) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        done_err   <= 1'b1;
                        done_full  <= 1'b0;
                        done_added <= '0;
                        done_left  <= list_len - ent_idx;
                    end
                    if (close_prev) begin
                        cl_valid <= 1'b1;
                        cl_slot  <= open_slot;
                        cl_count <= bcount;
                    end
                    if (stop_full) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        done_err   <= 1'b0;
                        done_full  <= 1'b1;
                        done_added <= added;
                        done_left  <= list_len - ent_idx;
                    end
                    if (accept) begin
                        raddr     <= raddr + 64'(ent_len);
                        next_addr <= ent_addr + 64'(ent_len);
                        ent_idx   <= ent_idx + CNT_W'(1);
                        if (acc_merge) begin
                            bcount <= bcount + ent_len;
                        end else begin
                            bcount    <= ent_len;
                            open_slot <= slot;
                            have_open <= 1'b1;
                            op_valid  <= 1'b1;
                            op_slot   <= slot;
                            op_word0  <= bd_next.w0;
                            op_word1  <= bd_next.w1;
                            op_raddr  <= bd_next.raddr;
                            op_buf    <= bd_next.buf_addr;
                        end
                        if (ent_last) st <= ST_FLUSH;
                    end
                end
                ST_FLUSH: begin
                    st         <= ST_IDLE;
                    cl_valid   <= 1'b1;
                    cl_slot    <= open_slot;
                    cl_count   <= bcount;
                    have_open  <= 1'b0;
                    done       <= 1'b1;
                    done_err   <= 1'b0;
                    done_full  <= 1'b0;
                    done_added <= added;
                    done_left  <= '0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sg_coalescer_chk.sv
module sg_coalescer_chk #(
    parameter int N         = 128,
    parameter int LEN_W     = 26,
    parameter int MAX_BYTES = 67108863,
    parameter int CNT_W     = 32,
    parameter int SLOT_W    = $clog2(N + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ent_ready,
    input logic              busy,
    input logic              op_valid,
    input logic [SLOT_W-1:0] op_slot,
    input logic [31:0]       op_word0,
    input logic              cl_valid,
    input logic [LEN_W-1:0]  cl_count,
    input logic              done,
    input logic              done_err,
    input logic              done_full,
    input logic [CNT_W-1:0]  done_added
);
    localparam logic [LEN_W:0] CAP = (LEN_W + 1)'(MAX_BYTES);

    // R1
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ent_ready |-> busy);

    // R9
    no_link_slot_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_slot < SLOT_W'(N)));

    // R5
    desc_kind_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_word0[31:29] == 3'b001));

    // R2
    close_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> ({1'b0, cl_count} <= CAP && cl_count != '0));

    // R4
    err_nocommit_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> (done_added == '0 && !done_full));

    // R11
    final_close_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !done_err && !done_full) |-> cl_valid);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind sg_coalescer sg_coalescer_chk #(
    .N(N), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ent_ready  (ent_ready),
    .busy       (busy),
    .op_valid   (op_valid),
    .op_slot    (op_slot),
    .op_word0   (op_word0),
    .cl_valid   (cl_valid),
    .cl_count   (cl_count),
    .done       (done),
    .done_err   (done_err),
    .done_full  (done_full),
    .done_added (done_added)
);

// File: tb/sg_coalescer_bench.sv
module sg_coalescer_bench;
    localparam int N      = 8;
    localparam int LEN_W  = 12;
    localparam int MAXB   = 256;
    localparam int CNT_W  = 16;
    localparam int SLOT_W = $clog2(N + 1);

    typedef struct packed {
        logic [3:0]  scen;
        logic [63:0] addr;
        logic [11:0] len;
        logic        last;
    } ent_row_t;

    typedef struct packed {
        logic [15:0] pend;
        logic [15:0] rd;
        logic [15:0] sglen;
        logic [7:0]  nop;
        logic [7:0]  ncl;
        logic [15:0] sum;
        logic [15:0] added;
        logic        err;
        logic        full;
        logic [15:0] left;
    } scen_row_t;

    localparam int NENT = 16;
    localparam int NSC  = 6;

    localparam ent_row_t ENTS [NENT] = '{
        '{4'd0, 64'h1000, 12'h040, 1'b0},
        '{4'd0, 64'h1040, 12'h040, 1'b0},
        '{4'd0, 64'h1080, 12'h040, 1'b0},
        '{4'd0, 64'h2000, 12'h010, 1'b1},
        '{4'd1, 64'h3000, 12'h0C0, 1'b0},
        '{4'd1, 64'h30C0, 12'h080, 1'b1},
        '{4'd2, 64'h4000, 12'h020, 1'b1},
        '{4'd3, 64'h5000, 12'h010, 1'b0},
        '{4'd3, 64'h6000, 12'h010, 1'b0},
        '{4'd3, 64'h7000, 12'h010, 1'b0},
        '{4'd3, 64'h8000, 12'h010, 1'b1},
        '{4'd4, 64'h9000, 12'h010, 1'b0},
        '{4'd4, 64'hA000, 12'h101, 1'b0},
        '{4'd4, 64'hB000, 12'h010, 1'b1},
        '{4'd5, 64'hC000, 12'h080, 1'b0},
        '{4'd5, 64'hC080, 12'h080, 1'b1}
    };

    // pend, rd, sglen, opens, closes, close sum, added, err, full, left
    localparam scen_row_t SCS [NSC] = '{
        '{16'd0,  16'd7, 16'd4, 8'd2, 8'd2, 16'h0D0, 16'd2, 1'b0, 1'b0, 16'd0},
        '{16'd7,  16'd5, 16'd2, 8'd2, 8'd2, 16'h140, 16'd3, 1'b0, 1'b0, 16'd0},
        '{16'd17, 16'd3, 16'd1, 8'd1, 8'd1, 16'h020, 16'd2, 1'b0, 1'b0, 16'd0},
        '{16'd0,  16'd2, 16'd4, 8'd2, 8'd2, 16'h020, 16'd2, 1'b0, 1'b1, 16'd2},
        '{16'd0,  16'd7, 16'd3, 8'd1, 8'd0, 16'h000, 16'd0, 1'b1, 1'b0, 16'd2},
        '{16'd3,  16'd0, 16'd2, 8'd1, 8'd1, 16'h100, 16'd1, 1'b0, 1'b0, 16'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] pend_cnt = '0, rd_cnt = '0, sg_len = '0;
    logic [63:0] raddr_in = 64'h1000_0001;
    logic [15:0] dest_id = 16'h00A5;
    logic [3:0]  ttype = 4'd5;
    logic ent_valid = 1'b0, ent_last = 1'b0;
    logic [63:0] ent_addr = '0;
    logic [LEN_W-1:0] ent_len = '0;
    logic ent_ready, op_valid, cl_valid, busy, done, done_err, done_full;
    logic [SLOT_W-1:0] op_slot, cl_slot;
    logic [31:0] op_word0, op_word1;
    logic [63:0] op_raddr, op_buf;
    logic [LEN_W-1:0] cl_count;
    logic [CNT_W-1:0] done_added, done_left;

    always #5 clk = ~clk;

    sg_coalescer #(.N(N), .LEN_W(LEN_W), .MAX_BYTES(MAXB), .CNT_W(CNT_W)) u_sg_coalescer (
        .clk(clk), .rst(rst), .start(start), .pend_cnt(pend_cnt), .rd_cnt(rd_cnt),
        .sg_len(sg_len), .raddr_in(raddr_in), .dest_id(dest_id), .ttype(ttype),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr),
        .ent_len(ent_len), .ent_last(ent_last), .op_valid(op_valid), .op_slot(op_slot),
        .op_word0(op_word0), .op_word1(op_word1), .op_raddr(op_raddr), .op_buf(op_buf),
        .cl_valid(cl_valid), .cl_slot(cl_slot), .cl_count(cl_count), .busy(busy),
        .done(done), .done_err(done_err), .done_full(done_full),
        .done_added(done_added), .done_left(done_left)
    );

    int n_chk = 0;
    int n_bad = 0;

    // event log, filled at the falling edge
    int n_op, n_cl, cl_sum;
    logic done_seen, cl_at_done, d_err, d_full;
    logic [CNT_W-1:0] d_added, d_left;
    logic [SLOT_W-1:0] lg_slot [8];
    logic [31:0] lg_w0 [8];
    logic [31:0] lg_w1 [8];
    logic [63:0] lg_ra [8];
    logic [63:0] lg_buf [8];

    always @(negedge clk) begin
        if (op_valid && n_op < 8) begin
            lg_slot[n_op] = op_slot;
            lg_w0[n_op]   = op_word0;
            lg_w1[n_op]   = op_word1;
            lg_ra[n_op]   = op_raddr;
            lg_buf[n_op]  = op_buf;
            n_op = n_op + 1;
        end
        if (cl_valid) begin
            n_cl = n_cl + 1;
            cl_sum = cl_sum + int'(cl_count);
        end
        if (done) begin
            done_seen  = 1'b1;
            cl_at_done = cl_valid;
            d_err      = done_err;
            d_full     = done_full;
            d_added    = done_added;
            d_left     = done_left;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic run_scen(input int s);
        n_op = 0; n_cl = 0; cl_sum = 0; done_seen = 1'b0; cl_at_done = 1'b0;
        @(posedge clk); #2;
        pend_cnt = SCS[s].pend; rd_cnt = SCS[s].rd; sg_len = SCS[s].sglen;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        for (int e = 0; e < NENT; e++) begin
            if (int'(ENTS[e].scen) == s) begin
                logic acc;
                ent_valid = 1'b1;
                ent_addr  = ENTS[e].addr;
                ent_len   = ENTS[e].len;
                ent_last  = ENTS[e].last;
                @(negedge clk);
                acc = ent_ready;
                @(posedge clk); #2;
                if (!acc || ENTS[e].last) break;
            end
        end
        ent_valid = 1'b0;
        while (!done_seen) @(posedge clk);
        @(negedge clk);
        check(n_op == int'(SCS[s].nop), "R3 open count", 64'(n_op), 64'(SCS[s].nop));
        check(n_cl == int'(SCS[s].ncl), "R11 close count", 64'(n_cl), 64'(SCS[s].ncl));
        check(cl_sum == int'(SCS[s].sum), "R2 close byte sum", 64'(cl_sum), 64'(SCS[s].sum));
        check(d_added == SCS[s].added, "R12 added count", 64'(d_added), 64'(SCS[s].added));
        check(d_err == SCS[s].err, "R4 error flag", 64'(d_err), 64'(SCS[s].err));
        check(d_full == SCS[s].full, "R10 full flag", 64'(d_full), 64'(SCS[s].full));
        check(d_left == SCS[s].left, "R10 residue", 64'(d_left), 64'(SCS[s].left));
        if (!SCS[s].err && !SCS[s].full)
            check(cl_at_done, "R11 final close with done", 64'(cl_at_done), 64'd1);
        if (busy) check(1'b0, "R12 idle after done", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !ent_ready && !done && !op_valid && !cl_valid, "R1 reset idle",
              64'({busy, ent_ready, done, op_valid, cl_valid}), 64'd0);

        for (int s = 0; s < NSC; s++) begin
            run_scen(s);
            if (s == 0) begin
                // R5 / R6 fields of first open
                check(lg_w0[0] == 32'h2028_00A5, "R5 word0", 64'(lg_w0[0]), 64'h202800A5);
                check(lg_w1[0] == 32'h4000_0000, "R6 word1", 64'(lg_w1[0]), 64'h40000000);
                check(lg_ra[0] == 64'h0400_0000, "R6 shifted raddr", lg_ra[0], 64'h04000000);
                check(lg_buf[0] == 64'h1000, "R6 buffer addr", lg_buf[0], 64'h1000);
                // R7 remote address advanced over merged entries
                check(lg_ra[1] == 64'h0400_0030, "R7 raddr advance", lg_ra[1], 64'h04000030);
                check(lg_slot[1] == SLOT_W'(1), "R3 second slot", 64'(lg_slot[1]), 64'd1);
            end
            if (s == 1) begin
                // R9 wrap past last data slot
                check(lg_slot[0] == SLOT_W'(7), "R9 start slot", 64'(lg_slot[0]), 64'd7);
                check(lg_slot[1] == SLOT_W'(0), "R9 wrapped slot", 64'(lg_slot[1]), 64'd0);
            end
            if (s == 2) begin
                // R8 start on link slot
                check(lg_slot[0] == SLOT_W'(0), "R8 link start", 64'(lg_slot[0]), 64'd0);
            end
            if (s == 3) begin
                check(lg_slot[1] == SLOT_W'(1), "R10 last opened slot", 64'(lg_slot[1]), 64'd1);
            end
            if (s == 5) begin
                check(lg_slot[0] == SLOT_W'(3), "R8 pend modulo", 64'(lg_slot[0]), 64'd3);
            end
        end

        // R4 ignored oversize entry left nothing running: a new pass works
        check(!busy, "R4 idle after error", 64'(busy), 64'd0);
        finish_run();
    end
endmodule